// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This block keeps the interrupt state of an I2C controller. Single-cycle event pulses from the bus engine and the FIFOs set sticky bits in a 16-bit status register. Software reads that register and clears bits by writing ones to them. An interrupt-enable mask selects which causes drive a level interrupt output. A wakeup-enable mask selects which sources drive a wakeup request output.

A second view of the same state serves older software. It is an encoded vector register. Reading it returns a small code for the lowest-numbered pending cause and clears that cause. The vector and the wakeup-enable register share one address: a read returns the vector and a write loads the wakeup mask.

All registers are reached through a simple request/write-enable register port. Read data appears one cycle after the request.

Top module: `i2c_evt_irq`

## Requirements
- R1: A one-cycle pulse on `evt_i[n]` sets status bit n from the next clock edge, and the bit stays set. This applies to the sticky positions 0 (arbitration lost), 1 (no-acknowledge), 2 (access ready), 3 (receive ready), 4 (transmit ready), 8 (address zero), 9 (addressed as slave), 10 (transmit underflow), 11 (receive overrun), 13 (receive drain) and 14 (transmit drain). Pulses on bits 5 to 7, 12 and 15 set nothing.
- R2: A write to offset 0x08 clears every sticky status bit whose write-data bit is one. Bits written with zero keep their value.
- R3: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit is set after that edge.
- R4: Status bit 12 reads the live `bus_busy_i` level, as sampled in the read cycle. Writes to it have no effect, and it never raises the interrupt.
- R5: The interrupt-enable register at offset 0x04 holds only bits 0 to 4, 13 and 14. All other bits read back as zero.
- R6: `irq_o` goes high one cycle after any status bit is set while its enable bit is set. It stays high until no enabled bit remains set.
- R7: A read of offset 0x0C returns the vector code. The code is 0 when none of status bits 0 to 4 is set. Otherwise it is n+1 for the lowest set bit n (1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready). The code does not depend on the enable mask.
- R8: A vector read clears only the status bit it reported. An event on that bit in the same cycle keeps the bit set.
- R9: A write to offset 0x0C loads the wakeup mask; only bits 0, 1, 2, 3, 5, 6, 8, 9, 13 and 14 are kept. One cycle later, `wake_o` is the OR of the enabled sources. Bits 0, 1, 2, 9, 13 and 14 come from the status bits at the same positions. Bit 3 is status bit 3 OR status bit 4. Bit 5 is `gcall_i`, bit 6 is `start_i`, and bit 8 is bus free, which is NOT `bus_busy_i`.
- R10: After reset, all registers and outputs are zero. Read data updates one cycle after a read request and holds between reads. A read of any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after a read request |
| evt_i | input | 16 | Event pulses, one per status position |
| bus_busy_i | input | 1 | Live bus-busy level |
| gcall_i | input | 1 | General-call detected (wakeup source) |
| start_i | input | 1 | Start condition detected (wakeup source) |
| irq_o | output | 1 | Level interrupt |
| wake_o | output | 1 | Wakeup request |

## Verification
The assertions take for granted that every access lasts one cycle. They also assume the address and write-enable inputs hold steady for the whole request cycle. Event pulses may arrive on any bit in any cycle, even together with an access to the same bit; the bench relies on exactly this to exercise the set-wins and vector-clear races. The directed phases drive one access per cycle with fields set at the falling edge. The random phase mixes sparse event pulses, bus-busy toggles and accesses to mapped and unmapped offsets. A behavioural model is compared with the outputs on every cycle.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned NVEC     = 5;   // causes reported by the vector
  localparam int unsigned VEC_W    = $clog2(NVEC + 1);
  localparam int unsigned BUSY_BIT = 12;
  localparam int unsigned WK_DRDY  = 3;
  localparam int unsigned WK_GC    = 5;
  localparam int unsigned WK_STT   = 6;
  localparam int unsigned WK_BFREE = 8;

  localparam logic [REG_W-1:0] STICKY_M  = 16'h6F1F;
  localparam logic [REG_W-1:0] IE_M      = 16'h601F;
  localparam logic [REG_W-1:0] WAKE_M    = 16'h636F;
  localparam logic [REG_W-1:0] WK_FROM_ST = 16'h6207;  // wake bits copied from status

  localparam int unsigned OFS_IE = 'h04;
  localparam int unsigned OFS_ST = 'h08;
  localparam int unsigned OFS_VW = 'h0C;
endpackage

// File: rtl/i2c_evt_status.sv
module i2c_evt_status #(
  parameter int unsigned    DW   = 16,
  parameter logic [DW-1:0] KEEP = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] st_o
);
  for (genvar g = 0; g < DW; g++) begin : g_bit
    if (KEEP[g]) begin : g_sticky
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= set_i[g] | (bit_q & ~clr_i[g]);
      end
      assign st_o[g] = bit_q;

      assert_evt_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[g] |=> st_o[g]);
      assert_w1c_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[g] && !set_i[g]) |=> !st_o[g]);
      assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i[g] && st_o[g]) |=> st_o[g]);
      assert_set_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[g] && set_i[g]) |=> st_o[g]);
    end else begin : g_none
      assign st_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_evt_vec.sv
module i2c_evt_vec #(
  parameter int unsigned N  = 5,
  parameter int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  pend_i,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  hit_o
);
  // lowest index wins: scan downward, last assignment sticks
  always_comb begin
    code_o = '0;
    hit_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        code_o   = CW'(i + 1);
        hit_o    = '0;
        hit_o[i] = 1'b1;
      end
    end
  end

  always_comb begin
    assert_one_cause_R7: assert ($onehot0(hit_o));
    assert_zero_code_R7: assert ((code_o == '0) == (pend_i == '0));
  end
endmodule

// File: rtl/i2c_evt_out.sv
module i2c_evt_out #(
  parameter int unsigned    DW      = 16,
  parameter logic [DW-1:0] IRQ_M   = '1,
  parameter logic [DW-1:0] COPY_M  = '0,
  parameter int unsigned    B_DRDY  = 3,
  parameter int unsigned    B_GC    = 5,
  parameter int unsigned    B_STT   = 6,
  parameter int unsigned    B_BFREE = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] st_i,
  input  logic [DW-1:0] ie_i,
  input  logic [DW-1:0] wen_i,
  input  logic          gcall_i,
  input  logic          start_i,
  input  logic          bus_busy_i,
  output logic          irq_o,
  output logic          wake_o
);
  logic [DW-1:0] wsrc;
  logic          irq_q, wake_q;

  always_comb begin
    wsrc          = st_i & COPY_M;
    wsrc[B_DRDY]  = st_i[3] | st_i[4];
    wsrc[B_GC]    = gcall_i;
    wsrc[B_STT]   = start_i;
    wsrc[B_BFREE] = ~bus_busy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      irq_q  <= |(st_i & ie_i & IRQ_M);
      wake_q <= |(wsrc & wen_i);
    end
  end

  assign irq_o  = irq_q;
  assign wake_o = wake_q;

  assert_irq_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|(st_i & ie_i)));
  assert_irq_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(st_i & ie_i)) |=> irq_o);
  assert_gc_wake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gcall_i && wen_i[B_GC]) |=> wake_o);
endmodule

// File: rtl/i2c_evt_irq.sv
module i2c_evt_irq
  import i2c_evt_pkg::*;
#(
  parameter int unsigned DW = REG_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] evt_i,
  input  logic          bus_busy_i,
  input  logic          gcall_i,
  input  logic          start_i,
  output logic          irq_o,
  output logic          wake_o
);
  localparam logic [DW-1:0] KEEP_M = DW'(STICKY_M);
  localparam logic [DW-1:0] IEN_M  = DW'(IE_M);
  localparam logic [DW-1:0] WEN_M  = DW'(WAKE_M);

  logic          rd, wr, sel_ie, sel_st, sel_vw;
  logic [DW-1:0] st_q, st_view, set_v, clr_v, ie_q, wen_q, rdata_q;
  logic [VEC_W-1:0] vcode;
  logic [NVEC-1:0]  vhit;

  assign rd     = req_i & ~we_i;
  assign wr     = req_i & we_i;
  assign sel_ie = addr_i == AW'(OFS_IE);
  assign sel_st = addr_i == AW'(OFS_ST);
  assign sel_vw = addr_i == AW'(OFS_VW);

  assign set_v = evt_i & KEEP_M;

  always_comb begin
    clr_v = '0;
    if (wr && sel_st) clr_v = wdata_i;
    if (rd && sel_vw) clr_v[NVEC-1:0] = clr_v[NVEC-1:0] | vhit;
  end

  i2c_evt_status #(.DW(DW), .KEEP(KEEP_M)) u_status (
    .clk_i, .rst_ni, .set_i(set_v), .clr_i(clr_v), .st_o(st_q)
  );

  i2c_evt_vec #(.N(NVEC), .CW(VEC_W)) u_vec (
    .pend_i(st_q[NVEC-1:0]), .code_o(vcode), .hit_o(vhit)
  );

  always_comb begin
    st_view           = st_q;
    st_view[BUSY_BIT] = bus_busy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= '0;
      wen_q <= '0;
    end else if (wr) begin
      if (sel_ie) ie_q  <= wdata_i & IEN_M;
      if (sel_vw) wen_q <= wdata_i & WEN_M;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) begin
      if (sel_ie)      rdata_q <= ie_q;
      else if (sel_st) rdata_q <= st_view;
      else if (sel_vw) rdata_q <= DW'(vcode);
      else             rdata_q <= '0;
    end
  end
  assign rdata_o = rdata_q;

  i2c_evt_out #(
    .DW(DW), .IRQ_M(IEN_M), .COPY_M(DW'(WK_FROM_ST)),
    .B_DRDY(WK_DRDY), .B_GC(WK_GC), .B_STT(WK_STT), .B_BFREE(WK_BFREE)
  ) u_out (
    .clk_i, .rst_ni, .st_i(st_q), .ie_i(ie_q), .wen_i(wen_q),
    .gcall_i, .start_i, .bus_busy_i, .irq_o, .wake_o
  );

  assert_busy_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel_st) |=> rdata_o[BUSY_BIT] == $past(bus_busy_i));
  assert_ie_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel_ie) |=> (rdata_o & ~IEN_M) == '0);
  assert_vec_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel_vw && |vhit && !(|(evt_i[NVEC-1:0] & vhit)))
      |=> !(|(st_q[NVEC-1:0] & $past(vhit))));
  assert_vec_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel_vw && !(wr) && !(|(evt_i[NVEC-1:0]))) |=>
      ((st_q[NVEC-1:0] | $past(vhit)) == $past(st_q[NVEC-1:0])));
  assert_unmapped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !sel_ie && !sel_st && !sel_vw) |=> rdata_o == '0);
endmodule

// File: tb/i2c_evt_irq_test.sv
module i2c_evt_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0, evt = '0;
  logic        busy = 1'b0, gc = 1'b0, stt = 1'b0;
  logic [15:0] rdata;
  logic        irq, wake;

  always #4 clk = ~clk;  // 125 MHz

  i2c_evt_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .bus_busy_i(busy),
    .gcall_i(gc), .start_i(stt), .irq_o(irq), .wake_o(wake)
  );

  // behavioural reference
  logic [15:0] m_st = '0, m_ie = '0, m_we = '0, m_rd = '0;
  logic        m_irq = 1'b0, m_wake = 1'b0;
  logic [15:0] k_clr, k_src;
  logic [2:0]  k_code;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '0; m_ie = '0; m_we = '0; m_rd = '0; m_irq = 1'b0; m_wake = 1'b0;
    end else begin
      k_code = 3'd0;
      for (int i = 4; i >= 0; i--) if (m_st[i]) k_code = 3'(i + 1);
      k_clr = '0;
      if (req && we && addr == 8'h08) k_clr = wdata;
      if (req && !we && addr == 8'h0C && k_code != 0) k_clr[k_code - 1] = 1'b1;
      k_src = m_st & 16'h6207;
      k_src[3] = m_st[3] | m_st[4];
      k_src[5] = gc;
      k_src[6] = stt;
      k_src[8] = !busy;
      m_irq  = |(m_st & m_ie);
      m_wake = |(k_src & m_we);
      if (req && !we) begin
        case (addr)
          8'h04:   m_rd = m_ie;
          8'h08:   m_rd = (m_st & 16'h6F1F) | (16'(busy) << 12);
          8'h0C:   m_rd = 16'(k_code);
          default: m_rd = '0;
        endcase
      end
      if (req && we && addr == 8'h04) m_ie = wdata & 16'h601F;
      if (req && we && addr == 8'h0C) m_we = wdata & 16'h636F;
      m_st = ((m_st & ~k_clr) | evt) & 16'h6F1F;
    end
  end

  int    n_chk = 0, n_bad = 0;
  string tag = "R10";
  logic  done = 1'b0;

  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (rdata !== m_rd || irq !== m_irq || wake !== m_wake) begin
        n_bad++;
        $display("FAIL %s t=%0t rdata/irq/wake actual %h/%b/%b expected %h/%b/%b",
                 tag, $time, rdata, irq, wake, m_rd, m_irq, m_wake);
      end
    end
  end

  task automatic step(input logic r, input logic w, input logic [7:0] a,
                      input logic [15:0] d, input logic [15:0] e);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; evt = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 16'h0, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R10"; idle(2);
    step(1, 0, 8'h08, 0, 0); step(1, 0, 8'h10, 0, 0); step(1, 0, 8'h0C, 0, 0); idle(2);

    tag = "R1";
    for (int b = 0; b < 16; b++) begin
      step(0, 0, 0, 0, 16'(1) << b);
      step(1, 0, 8'h08, 0, 0);
      step(1, 1, 8'h08, 16'hFFFF, 0);
    end
    idle(2);

    tag = "R2";
    step(0, 0, 0, 0, 16'h6F1F);
    step(1, 1, 8'h08, 16'h0105, 0); step(1, 0, 8'h08, 0, 0);
    step(1, 1, 8'h08, 16'h0000, 0); step(1, 0, 8'h08, 0, 0);
    step(1, 1, 8'h08, 16'h4A10, 0); step(1, 0, 8'h08, 0, 0);
    step(1, 1, 8'h08, 16'hFFFF, 0); step(1, 0, 8'h08, 0, 0);

    tag = "R3";
    step(0, 0, 0, 0, 16'h0003);
    step(1, 1, 8'h08, 16'h0003, 16'h0001); step(1, 0, 8'h08, 0, 0);
    step(1, 1, 8'h08, 16'hFFFF, 0); idle(1);

    tag = "R5";
    step(1, 1, 8'h04, 16'hFFFF, 0); step(1, 0, 8'h04, 0, 0);
    step(1, 1, 8'h04, 16'h0000, 0); step(1, 0, 8'h04, 0, 0);

    tag = "R6";
    step(1, 1, 8'h04, 16'h0004, 0);
    step(0, 0, 0, 0, 16'h0008); idle(2);
    step(0, 0, 0, 0, 16'h0004); idle(3);
    step(1, 1, 8'h08, 16'h0004, 0); idle(2);
    step(1, 1, 8'h04, 16'h601F, 0);
    step(0, 0, 0, 0, 16'h4000); idle(2);
    step(1, 1, 8'h08, 16'hFFFF, 0); idle(2);

    tag = "R4";
    busy = 1'b1;
    step(1, 1, 8'h04, 16'hFFFF, 0);
    step(1, 0, 8'h08, 0, 16'h1000); step(1, 1, 8'h08, 16'h1000, 0);
    step(1, 0, 8'h08, 0, 0); idle(2);
    busy = 1'b0; step(1, 0, 8'h08, 0, 0); idle(1);
    step(1, 1, 8'h04, 16'h0000, 0);

    tag = "R7";
    step(0, 0, 0, 0, 16'h001A);
    step(1, 0, 8'h0C, 0, 0); step(1, 0, 8'h0C, 0, 0);
    tag = "R8";
    step(1, 0, 8'h0C, 0, 0); step(1, 0, 8'h08, 0, 0);
    step(1, 0, 8'h0C, 0, 0); step(1, 0, 8'h0C, 0, 0);
    step(0, 0, 0, 0, 16'h0006);
    step(1, 0, 8'h0C, 0, 16'h0002); step(1, 0, 8'h0C, 0, 0);
    step(1, 0, 8'h0C, 0, 0); step(1, 0, 8'h0C, 0, 0); idle(1);

    tag = "R9";
    busy = 1'b1;
    step(1, 1, 8'h0C, 16'hFFFF, 0); idle(2);
    gc = 1'b1; idle(1); gc = 1'b0; idle(1);
    stt = 1'b1; idle(1); stt = 1'b0; idle(1);
    step(0, 0, 0, 0, 16'h0010); idle(2);
    step(1, 1, 8'h08, 16'hFFFF, 0); idle(1);
    busy = 1'b0; idle(2); busy = 1'b1;
    step(1, 1, 8'h0C, 16'h0020, 0); step(0, 0, 0, 0, 16'h0010); idle(2);
    step(1, 1, 8'h08, 16'hFFFF, 0); idle(2);

    tag = "R1 R2 R3 R6 R7 R8 R9 mixed";
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      logic [15:0] e;
      case ($urandom_range(0, 4))
        0: a = 8'h04; 1: a = 8'h08; 2: a = 8'h0C; 3: a = 8'h08;
        default: a = 8'h10 + 8'($urandom_range(0, 3) * 4);
      endcase
      e = ($urandom_range(0, 3) == 0) ? 16'($urandom) & 16'($urandom) : 16'h0;
      if ($urandom_range(0, 15) == 0) busy = ~busy;
      gc  = ($urandom_range(0, 7) == 0);
      stt = ($urandom_range(0, 7) == 0);
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, 16'($urandom), e);
    end
    gc = 1'b0; stt = 1'b0;
    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog %s actual running expected finished", tag);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule